// File: doc/BRIEF.md
# Mersenne Number Primality Tester

This block decides whether the Mersenne number 2^p-1 is prime for an exponent p that fits the 16-bit datapath. A single-cycle start strobe captures the exponent and the block forms the modulus from it. The working residue is seeded with 4. The block then applies the Lucas-Lehmer recurrence: square the residue modulo the Mersenne number, take away 2, and repeat p-2 times. At the end it checks whether the residue is zero and reports the verdict.

The squaring runs on a shift-and-add modular multiplier that spends one cycle per multiplier bit. Because 2^p is congruent to 1 modulo 2^p-1, each doubling reduces with a single compare and subtract. The caller pulses start with an exponent, waits for the one-cycle done strobe, and then reads is_prime, err and the final residue. These outputs stay steady until the next accepted start.

Top module: `llt_tester`

## Requirements
- R1: After a synchronous active-low reset, busy, done, is_prime and err are all 0.
- R2: A start pulse while idle with 2 <= p_in <= 16 is accepted. busy is 1 in the next cycle, the modulus is 2^p-1, the residue is seeded with 4, and err reads 0 at the end of the run.
- R3: Each iteration replaces the residue S with (S*S - 2) mod (2^p-1). The subtraction wraps modulo 2^p-1, so a squared value of 0 or 1 becomes M-2 or M-1. For p >= 3 the residue stays below the modulus.
- R4: Exactly p-2 iterations are run. For p = 7 the residue passes through 4, 14, 67, 42, 111 and ends at 0, and the residue output shows the final value.
- R5: is_prime is 1 exactly when the final residue is 0. The exception is p = 2, where no iteration runs and the verdict is prime.
- R6: done is high for one cycle only, and busy falls on the same edge where done rises.
- R7: is_prime, err and residue hold their values until the next accepted start.
- R8: A start with p_in < 2 or p_in > 16 is rejected. done pulses on the edge that samples the start, err is 1, is_prime is 0, busy stays 0, and residue keeps its previous value.
- R9: A start pulse while busy is ignored, and the run in progress finishes with its original exponent.
- R10: Counting edges with the start-sampling edge as the first, done rises on edge 2 + (p-2)*(W+2) for an accepted exponent (W = 16), and on edge 1 for a rejected one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to test p_in |
| p_in | input | 16 | Exponent p of the number 2^p-1 |
| busy | output | 1 | A test run is in progress |
| done | output | 1 | One-cycle strobe: verdict is ready |
| is_prime | output | 1 | 2^p-1 is prime (valid after done) |
| err | output | 1 | Last start was rejected for a bad exponent |
| residue | output | 16 | Residue register; the final residue after done |

## Verification
The bench builds the block with its default width W = 16. This allows every legal exponent from 2 to 16, including the full 16-bit modulus 65535 where carry-out into bit 16 matters during reduction. It also allows exponents 17 and up, which are outside the range. Directed runs cover p = 2, 3, 7, 11 and 16, rejected exponents, and a start strobe injected mid-run. Seeded random exponents then sweep the legal range. Each run is compared against a 64-bit reference recurrence and the exact latency formula.

// File: rtl/llt_pkg.sv
// Package: shared types for the Mersenne primality tester.
// Assumes: nothing beyond IEEE 1800-2017.
package llt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_WAIT = 2'd2
    } llt_state_t;
endpackage

// File: rtl/llt_iter_ctr.sv
// Module: iteration counter for the recurrence.
// Assumes: clr and inc are never high in the same cycle.
module llt_iter_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Clear on a new run, step once per finished iteration.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/llt_mod_sub2.sv
// Module: subtract 2 modulo m, wrapping low values upward.
// Assumes: s_i < m_i and m_i >= 3, so the result is below m_i.
module llt_mod_sub2 #(
    parameter int W = 16
) (
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] m_i,
    output logic [W-1:0] d_o
);
    // Plain subtract when it stays non-negative, otherwise add the modulus back.
    always_comb begin
        if (s_i >= W'(2)) d_o = s_i - W'(2);
        else              d_o = s_i + m_i - W'(2);
    end
endmodule

// File: rtl/llt_modmul.sv
// Module: serial shift-and-add modular multiplier, one multiplier bit per cycle.
// Scans b from MSB to LSB: acc = (2*acc + bit*a) mod m, with one conditional
// subtract after the doubling and one after the add.
// Assumes: a_i < m_i and b_i < 2^W; go is only pulsed when idle.
// Latency: done_o rises W edges after the edge that samples go.
module llt_modmul #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] m_i,
    output logic         done_o,
    output logic [W-1:0] prod_o
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  acc, a_q, b_q, m_q, acc_nxt;
    logic [IW-1:0] idx;
    logic          run;
    logic [W:0]    dbl, sum;

    // One reduction step: double, reduce, conditionally add a, reduce.
    always_comb begin
        dbl = {acc, 1'b0};
        if (dbl >= {1'b0, m_q}) dbl = dbl - {1'b0, m_q};
        sum = dbl + (b_q[idx] ? {1'b0, a_q} : '0);
        if (sum >= {1'b0, m_q}) sum = sum - {1'b0, m_q};
        acc_nxt = sum[W-1:0];
    end

    // Load operands on go, then walk the multiplier bits down to bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0; a_q <= '0; b_q <= '0; m_q <= '0;
            idx <= '0; run <= 1'b0; done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go) begin
                acc <= '0; a_q <= a_i; b_q <= b_i; m_q <= m_i;
                idx <= IW'(W - 1);
                run <= 1'b1;
            end else if (run) begin
                acc <= acc_nxt;
                if (idx == '0) begin
                    run    <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    idx <= idx - IW'(1);
                end
            end
        end
    end

    assign prod_o = acc;

    // The finished product is fully reduced.
    assert_prod_reduced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (prod_o < m_q));
endmodule

// File: rtl/llt_tester.sv
// Module: Lucas-Lehmer primality tester for 2^p-1 (top).
// On an accepted start: modulus = 2^p-1, residue = 4, then p-2 rounds of
// residue = (residue^2 - 2) mod modulus; prime when the final residue is 0
// (p = 2 is reported prime directly).
// Assumes: start is a single-cycle strobe; exponents outside 2..W are rejected.
module llt_tester
    import llt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] p_in,
    output logic         busy,
    output logic         done,
    output logic         is_prime,
    output logic         err,
    output logic [W-1:0] residue
);
    localparam logic [W-1:0] P_MIN = W'(2);
    localparam logic [W-1:0] P_MAX = W'(W);
    localparam logic [W-1:0] SEED  = W'(4);

    llt_state_t   state;
    logic [W-1:0] p_q, mod_q, res_q, target, cnt, sub_out, mul_prod;
    logic [W:0]   m_full;
    logic         p_ok, at_end, mul_go, mul_done, cnt_clr, cnt_inc;

    // Decode the request and the loop-end condition.
    always_comb begin
        p_ok    = (p_in >= P_MIN) && (p_in <= P_MAX);
        m_full  = ((W+1)'(1) << p_in) - (W+1)'(1);
        target  = p_q - W'(2);
        at_end  = (cnt == target);
        mul_go  = (state == ST_LOOP) && !at_end;
        cnt_clr = (state == ST_IDLE) && start && p_ok;
        cnt_inc = (state == ST_WAIT) && mul_done;
    end

    llt_iter_ctr #(.W(W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .count(cnt)
    );

    llt_modmul #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n), .go(mul_go),
        .a_i(res_q), .b_i(res_q), .m_i(mod_q),
        .done_o(mul_done), .prod_o(mul_prod)
    );

    llt_mod_sub2 #(.W(W)) u_sub (
        .s_i(mul_prod), .m_i(mod_q), .d_o(sub_out)
    );

    // Control FSM: accept or reject, iterate, deliver the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; done <= 1'b0; is_prime <= 1'b0; err <= 1'b0;
            p_q <= '0; mod_q <= '0; res_q <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    if (p_ok) begin
                        p_q      <= p_in;
                        mod_q    <= m_full[W-1:0];
                        res_q    <= SEED;
                        err      <= 1'b0;
                        is_prime <= 1'b0;
                        state    <= ST_LOOP;
                    end else begin
                        done     <= 1'b1;
                        err      <= 1'b1;
                        is_prime <= 1'b0;
                    end
                end
                ST_LOOP: if (at_end) begin
                    done     <= 1'b1;
                    is_prime <= (p_q == P_MIN) || (res_q == '0);
                    state    <= ST_IDLE;
                end else begin
                    state <= ST_WAIT;
                end
                ST_WAIT: if (mul_done) begin
                    res_q <= sub_out;
                    state <= ST_LOOP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign residue = res_q;

    // Residue stays reduced throughout a run with p >= 3.
    assert_res_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && p_q > P_MIN) |-> (res_q < mod_q));
    // The iteration count never passes p-2.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= target));
    // done lasts one cycle unless a fresh start follows at once.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);
    // A rejected exponent never carries a prime verdict.
    assert_err_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !is_prime);
    // A start during a run leaves the latched exponent alone.
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(p_q));
endmodule

// File: tb/llt_tester_tb.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random exponents against a reference recurrence.
module llt_tester_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] p_in = '0;
    logic         busy, done, is_prime, err;
    logic [W-1:0] residue;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    llt_tester #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .p_in(p_in),
        .busy(busy), .done(done), .is_prime(is_prime), .err(err), .residue(residue)
    );

    // Reference recurrence in 64-bit arithmetic.
    function automatic longint ref_res(input int p);
        longint m, s;
        m = (longint'(1) << p) - 1;
        s = 4;
        for (int i = 0; i < p - 2; i++) s = (s * s + m - 2) % m;
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One run: drive start, optionally inject a start mid-run, check everything.
    task automatic run(input int p, input bit inject);
        bit     ok_p;
        int     n, exp_n;
        longint exp_r;
        logic [W-1:0] prev_res;
        ok_p     = (p >= 2) && (p <= W);
        prev_res = residue;
        exp_r    = ok_p ? ref_res(p) : longint'(prev_res);
        exp_n    = ok_p ? 2 + (p - 2) * (W + 2) : 1;
        p_in  = W'(p);
        start = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start = 1'b0;
                if (ok_p) chk(busy == 1'b1, "R2 busy after accept", busy, 1);
                else      chk(busy == 1'b0, "R8 busy stays low", busy, 0);
            end
            if (inject && n == 20) begin start = 1'b1; p_in = W'(11); end
            if (inject && n == 21) start = 1'b0;
            if (done) break;
            if (n > 5000) begin
                chk(1'b0, "R10 done timeout", n, exp_n);
                break;
            end
        end
        chk(n == exp_n, ok_p ? "R10 latency" : "R8 reject latency", n, exp_n);
        chk(err == !ok_p, ok_p ? "R2 err clear" : "R8 err set", err, !ok_p);
        chk(longint'(residue) == exp_r, ok_p ? "R3 R4 final residue" : "R8 residue kept",
            residue, exp_r);
        chk(is_prime == (ok_p && (p == 2 || exp_r == 0)), inject ? "R9 verdict" : "R5 verdict",
            is_prime, (ok_p && (p == 2 || exp_r == 0)));
        chk(busy == 1'b0, "R6 busy falls with done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R6 single-cycle done", done, 0);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int r;
        bit hp;
        logic [W-1:0] hr;
        r = $urandom(32'h5EED_1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && is_prime == 0 && err == 0, "R1 reset outputs",
            {busy, done, is_prime, err}, 0);

        run(7, 1'b0);      // R4 p=7 sequence ends at 0
        chk(residue == 0 && is_prime, "R4 p=7 prime", residue, 0);
        hp = is_prime; hr = residue;
        repeat (10) @(negedge clk);
        chk(is_prime == hp && residue == hr && err == 0, "R7 verdict held", residue, hr);

        run(2, 1'b0);      // R5 p=2 prime without iterations
        run(3, 1'b0);
        run(11, 1'b0);     // R5 2047 is composite
        run(16, 1'b0);     // full-width modulus
        run(0, 1'b0);      // R8 rejects
        run(1, 1'b0);
        run(17, 1'b0);
        run(300, 1'b0);
        repeat (5) @(negedge clk);
        chk(err == 1 && is_prime == 0, "R7 err held", err, 1);
        run(7, 1'b1);      // R9 start while busy ignored
        run(13, 1'b0);

        for (int k = 0; k < 20; k++) begin
            r = int'($urandom % 15) + 2;
            run(r, 1'b0);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule